// File: doc/BRIEF.md
# Sequential Shift-and-Add Multiplier

This block multiplies two unsigned operands over a fixed run of clock cycles. The datapath has three registers. One holds the multiplicand. One accumulates the upper half of the product. The third starts out holding the multiplier and collects the lower half of the product as it shifts right. A widened adder and a select/clear multiplexer form each new partial value. A state machine controller drives active-low load strobes, a two-bit shift-register mode code, and select and clear controls.

A caller applies both operands and pulses `start` while the block is not busy. The block then raises `busy` for one initialisation cycle and one cycle per operand bit. It then pulses `done` for a single cycle, and `product` holds the full-width result. The result stays unchanged until the next accepted start changes the registers.

Top module: `seq_mult`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `product` is all zeros.
- R2: A `start` sampled high while `busy` is 0 makes `busy` high from the next cycle for exactly W+1 cycles: one initialisation cycle, then W iterations. `done` is then high in the following cycle, W+1 edges after the accepting edge.
- R3: When `done` is high, `product` equals the unsigned product of the two operands, including the corner values 0, 1 and 2^W-1.
- R4: `done` is high for exactly one cycle, and `busy` is 0 while `done` is high.
- R5: A `start` sampled high while `busy` is 1 is ignored. The running operation's result and completion time are unchanged, and no extra `done` pulse occurs.
- R6: While `busy` is 0, `product` does not change from one cycle to the next, whatever the operand and `start` inputs do.
- R7: Operands are captured at the clock edge that ends the first busy cycle. Operand changes after that edge do not affect the result.
- R8: The carry out of each partial sum is kept, so a full-scale product such as 255 x 255 = 65025 (W=8) is exact.
- R9: A `start` sampled high in the same cycle as `done` is accepted and begins a new operation at once, with the R2 timing.
- R10: The shift register mode is always one of 00 (hold), 01 (shift right) or 11 (parallel load). The multiplicand strobe is active only together with mode 11. The clear control is active only while the high-product strobe is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a multiplication when not busy |
| op_a | input | W | Multiplicand |
| op_b | input | W | Multiplier |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| product | output | 2W | Unsigned product {high half, low half} |

## Verification
The checker evaluates the following on every cycle: the legality of the internal mode, strobe and clear codes, the busy-window length ending in `done`, the single-cycle `done` pulse that never overlaps `busy`, and the stability of `product` while idle. The correctness of the arithmetic can be shown only by the bench's scenarios, which compare results against a reference multiply. The same holds for ignoring a start issued mid-run, for operand changes after capture, and for a back-to-back start in the `done` cycle.

// File: rtl/mul_pkg.sv
package mul_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_INIT = 2'd1,
    ST_ITER = 2'd2,
    ST_DONE = 2'd3
  } mul_state_e;

  // shift register mode codes
  localparam logic [1:0] MODE_HOLD  = 2'b00;
  localparam logic [1:0] MODE_SHIFT = 2'b01;
  localparam logic [1:0] MODE_LOAD  = 2'b11;

  // partial value: clear wins, then sum or zero-extended accumulator
  function automatic logic [8:0] partial8(input logic [7:0] hp,
                                          input logic [7:0] mc,
                                          input logic       sel,
                                          input logic       clr);
    if (clr)      return 9'd0;
    else if (sel) return {1'b0, hp} + {1'b0, mc};
    else          return {1'b0, hp};
  endfunction

endpackage

// File: rtl/mul_ctrl.sv
module mul_ctrl #(
  parameter int W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       lsb,
  output logic       ld_mcnd_n,
  output logic       ld_hp_n,
  output logic [1:0] mode,
  output logic       sel_sum,
  output logic       clr,
  output logic       busy,
  output logic       done
);
  import mul_pkg::*;

  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  mul_state_e state, state_nx;
  logic [CW-1:0] cnt;
  logic          accept;
  logic          last_iter;

  assign accept    = start && (state == ST_IDLE || state == ST_DONE);
  assign last_iter = (cnt == LAST);

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE: if (accept) state_nx = ST_INIT;
      ST_INIT: state_nx = ST_ITER;
      ST_ITER: if (last_iter) state_nx = ST_DONE;
      ST_DONE: state_nx = accept ? ST_INIT : ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= state_nx;
      if (state == ST_ITER) cnt <= cnt + 1'b1;
      else                  cnt <= '0;
    end
  end

  always_comb begin
    ld_mcnd_n = 1'b1;
    ld_hp_n   = 1'b1;
    mode      = MODE_HOLD;
    sel_sum   = 1'b0;
    clr       = 1'b0;
    case (state)
      ST_INIT: begin
        ld_mcnd_n = 1'b0;
        ld_hp_n   = 1'b0;
        mode      = MODE_LOAD;
        clr       = 1'b1;
      end
      ST_ITER: begin
        ld_hp_n   = 1'b0;
        mode      = MODE_SHIFT;
        sel_sum   = lsb;
      end
      default: ;
    endcase
  end

  assign busy = (state == ST_INIT) || (state == ST_ITER);
  assign done = (state == ST_DONE);

endmodule

// File: rtl/mul_datapath.sv
module mul_datapath #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  input  logic           ld_mcnd_n,
  input  logic           ld_hp_n,
  input  logic [1:0]     mode,
  input  logic           sel_sum,
  input  logic           clr,
  output logic           lsb,
  output logic [2*W-1:0] product
);
  import mul_pkg::*;

  logic [W-1:0] mcnd_q, hp_q, mpl_q;
  logic [W:0]   part;

  always_comb begin
    if (clr)          part = '0;
    else if (sel_sum) part = {1'b0, hp_q} + {1'b0, mcnd_q};
    else              part = {1'b0, hp_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcnd_q <= '0;
      hp_q   <= '0;
      mpl_q  <= '0;
    end else begin
      if (!ld_mcnd_n) mcnd_q <= op_a;
      if (!ld_hp_n)   hp_q   <= part[W:1];
      case (mode)
        MODE_LOAD:  mpl_q <= op_b;
        MODE_SHIFT: mpl_q <= {part[0], mpl_q[W-1:1]};
        default:    mpl_q <= mpl_q;
      endcase
    end
  end

  assign lsb     = mpl_q[0];
  assign product = {hp_q, mpl_q};

endmodule

// File: rtl/seq_mult.sv
module seq_mult #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  output logic           busy,
  output logic           done,
  output logic [2*W-1:0] product
);

  logic       ld_mcnd_n;
  logic       ld_hp_n;
  logic [1:0] mode;
  logic       sel_sum;
  logic       clr;
  logic       lsb;

  mul_ctrl #(.W(W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .lsb       (lsb),
    .ld_mcnd_n (ld_mcnd_n),
    .ld_hp_n   (ld_hp_n),
    .mode      (mode),
    .sel_sum   (sel_sum),
    .clr       (clr),
    .busy      (busy),
    .done      (done)
  );

  mul_datapath #(.W(W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_a      (op_a),
    .op_b      (op_b),
    .ld_mcnd_n (ld_mcnd_n),
    .ld_hp_n   (ld_hp_n),
    .mode      (mode),
    .sel_sum   (sel_sum),
    .clr       (clr),
    .lsb       (lsb),
    .product   (product)
  );

endmodule

// File: rtl/seq_mult_chk.sv
module seq_mult_chk #(
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           done,
  input logic [2*W-1:0] product,
  input logic           ld_mcnd_n,
  input logic           ld_hp_n,
  input logic [1:0]     mode,
  input logic           clr
);
  localparam int BW = $clog2(W + 3) + 1;
  logic [BW-1:0] bcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bcnt <= '0;
    else if (busy) bcnt <= bcnt + 1'b1;
    else           bcnt <= '0;
  end

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'b10); // R10
  AST_MCND_WITH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_mcnd_n |-> mode == 2'b11); // R10
  AST_CLR_WITH_HP: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> !ld_hp_n); // R10
  AST_BUSY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> bcnt == BW'(W + 1)); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R4
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R4
  AST_BUSY_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bcnt == BW'(W + 1)) |-> 1'b0); // R5
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(product)); // R6

endmodule

bind seq_mult seq_mult_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .product   (product),
  .ld_mcnd_n (ld_mcnd_n),
  .ld_hp_n   (ld_hp_n),
  .mode      (mode),
  .clr       (clr)
);

// File: tb/test_seq_mult.sv
module test_seq_mult;
  localparam int W = 8;
  localparam time PERIOD = 10;

  logic           clk = 0;
  logic           rst_n = 0;
  logic           start = 0;
  logic [W-1:0]   op_a = '0;
  logic [W-1:0]   op_b = '0;
  logic           busy, done;
  logic [2*W-1:0] product;

  int checks = 0;
  int errors = 0;

  always #(PERIOD/2) clk = ~clk;

  seq_mult #(.W(W)) i_seq_mult (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
    .busy(busy), .done(done), .product(product)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [2*W-1:0] acc = '0;
    for (int i = 0; i < W; i++) if (b[i]) acc += ({{W{1'b0}}, a} << i);
    return acc;
  endfunction

  // waits after an accepting edge until done; returns edges counted
  task automatic wait_done(output int lat);
    lat = 1;
    while (!done && lat < 60) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic run_mult(input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
    int lat;
    op_a = a; op_b = b; start = 1;
    @(negedge clk);
    start = 0;
    chk("R2 busy after start", busy, 1);
    wait_done(lat);
    chk("R2 latency", lat, W + 2);
    chk({"R3 product ", tag}, product, ref_mul(a, b));
    chk("R4 busy low at done", busy, 0);
    @(negedge clk);
    chk("R4 done one cycle", done, 0);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 product", product, 0);
  endtask

  task automatic t_corners();
    run_mult(0, 0, "0x0");
    run_mult(0, 255, "0x255");
    run_mult(255, 0, "255x0");
    run_mult(1, 1, "1x1");
    run_mult(1, 255, "1x255");
    run_mult(255, 1, "255x1");
    run_mult(255, 255, "R8 255x255");
    chk("R8 carry kept", product, 65025);
  endtask

  task automatic t_random();
    for (int i = 0; i < 24; i++) run_mult(W'($urandom), W'($urandom), "random");
  endtask

  task automatic t_start_busy();
    int lat;
    int extra = 0;
    op_a = 8'd37; op_b = 8'd201; start = 1;
    @(negedge clk);
    start = 0;
    @(negedge clk); @(negedge clk);
    start = 1; op_a = 8'd3; op_b = 8'd3;
    @(negedge clk);
    start = 0;
    lat = 4;
    while (!done && lat < 60) begin @(negedge clk); lat++; end
    chk("R5 timing unchanged", lat, W + 2);
    chk("R5 result unchanged", product, ref_mul(37, 201));
    chk("R7 late operand change ignored", product, 16'd7437);
    for (int i = 0; i < 15; i++) begin @(negedge clk); if (done) extra++; end
    chk("R5 no extra done", extra, 0);
  endtask

  task automatic t_idle_stable();
    logic [2*W-1:0] held;
    run_mult(8'd123, 8'd45, "pre-idle");
    held = product;
    for (int i = 0; i < 6; i++) begin
      op_a = W'($urandom); op_b = W'($urandom);
      @(negedge clk);
      chk("R6 product held while idle", product, held);
    end
  endtask

  task automatic t_back_to_back();
    int lat;
    op_a = 8'd200; op_b = 8'd150; start = 1;
    @(negedge clk);
    start = 0;
    wait_done(lat);
    chk("R3 first of pair", product, ref_mul(200, 150));
    op_a = 8'd17; op_b = 8'd99; start = 1;
    @(negedge clk);
    start = 0;
    chk("R9 busy right after done-cycle start", busy, 1);
    wait_done(lat);
    chk("R9 latency", lat, W + 2);
    chk("R9 second product", product, ref_mul(17, 99));
    @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_corners();
    t_random();
    t_start_busy();
    t_idle_stable();
    t_back_to_back();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule